// File: doc/BRIEF.md
# Privilege-Gated Opcode Group Decoder

This block turns an 8-bit instruction opcode into a one-hot vector of operation flags, registered on the rising clock edge. Every flag stands for one group of opcodes. A group always holds a power-of-two number of consecutive codes and begins on a multiple of its own size, so membership is decided by comparing only the upper bits of the opcode with the group's first code. Several groups are reserved for privileged execution: they can fire only while the kernel-mode input is high, and in user mode their codes fall through to the invalid flag.

A separate flag reports the shared bitwise-logic operations (AND, OR, XOR). The block does not execute anything and does not prove that an opcode is really undefined. A cycle-valid qualifier forces every output low on idle cycles. An error output reports when more than one output would be set in the same cycle, which can only happen if the group table is misconfigured.

Top module: `opgrp_decoder`

## Requirements
- R1: Bit i of `op_flags_o` belongs to the i-th group in ascending order of first code. A group with 2^n codes fires exactly when the top 8-n opcode bits equal those of its first code. The 26 single-code groups are, for bits 0..25: 0x01, 0x02, 0x03, 0x04, 0x06, 0x08, 0x09, 0x0C, 0x0D, 0x0E, 0x10, 0x11, 0x14, 0x15, 0x19, 0x1A, 0x1B, 0x1C, 0x21, 0x49, 0x50, 0x56, 0x57, 0x58, 0x5B and 0x5F. Bits 29..33 are the single codes 0xF6, 0xF7, 0xF9, 0xFB and 0xFC.
- R2: The wide groups are bit 26 (0x60..0x7F, n=5), bit 27 (0x80..0x8F, n=4) and bit 28 (0x90..0x9F, n=4). The codes on either side of each range (0x5F, 0xA0, and the 0x7F/0x80 and 0x8F/0x90 edges) go to the neighbouring decode.
- R3: The groups starting at 0x0C, 0x0D, 0x0E, 0x21, 0x49, 0xF6, 0xF7, 0xF9, 0xFB and 0xFC fire only when `kernel_i` is 1. All other groups fire in both modes.
- R4: When `valid_i` is 0, all outputs are 0 in the following cycle.
- R5: In any cycle, at most one of `op_flags_o`, `logic_op_o` and `invalid_o` is high.
- R6: A valid opcode that matches no available group and is not a logic opcode raises `invalid_o`. This includes a kernel-only code presented in user mode.
- R7: Opcodes 0x16, 0x17 and 0x18 raise `logic_op_o` and no other output.
- R8: Outputs appear one clock after the inputs are sampled. A synchronous active-high `rst` clears all outputs at the next edge.
- R9: `multi_hit_o` is high only when more than one of the group, logic and invalid decodes would fire. With the built-in table it stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Cycle-valid qualifier |
| kernel_i | input | 1 | Privileged-mode bit |
| opcode_i | input | 8 | Opcode to decode |
| op_flags_o | output | 34 | Registered one-hot group flags |
| logic_op_o | output | 1 | Registered combined AND/OR/XOR flag |
| invalid_o | output | 1 | Registered invalid-opcode flag |
| multi_hit_o | output | 1 | Registered table-conflict indicator |

## Verification
The bench decodes all 256 opcodes in both modes, so every range edge is exercised. An off-by-one mask would move 0x5F into the push range or leave 0xA0 decoded as a swap. Kernel-only codes in user mode must come out as invalid: a design that skips the privilege gate would raise an operation flag there instead. Idle cycles and a reset issued while a valid opcode is held show whether the qualifier and the reset truly clear the registers, and not only the flags.

// File: rtl/opdec_pkg.sv
package opdec_pkg;

  localparam int unsigned OPC_W      = 8;
  localparam int unsigned NUM_GROUPS = 34;
  localparam logic [OPC_W-1:0] LOGIC_LO = 8'h16;
  localparam logic [OPC_W-1:0] LOGIC_HI = 8'h18;

  typedef struct packed {
    logic [OPC_W-1:0] first;
    logic [3:0]       log2n;
    logic             priv;
  } grp_t;

  // Group descriptor i, ascending first code; index is the flag bit.
  function automatic grp_t grp_desc(input int unsigned i);
    grp_t g;
    g = '{first: 8'h00, log2n: 4'd8, priv: 1'b1};
    case (i)
      0:  g = '{8'h01, 4'd0, 1'b0};
      1:  g = '{8'h02, 4'd0, 1'b0};
      2:  g = '{8'h03, 4'd0, 1'b0};
      3:  g = '{8'h04, 4'd0, 1'b0};
      4:  g = '{8'h06, 4'd0, 1'b0};
      5:  g = '{8'h08, 4'd0, 1'b0};
      6:  g = '{8'h09, 4'd0, 1'b0};
      7:  g = '{8'h0C, 4'd0, 1'b1};
      8:  g = '{8'h0D, 4'd0, 1'b1};
      9:  g = '{8'h0E, 4'd0, 1'b1};
      10: g = '{8'h10, 4'd0, 1'b0};
      11: g = '{8'h11, 4'd0, 1'b0};
      12: g = '{8'h14, 4'd0, 1'b0};
      13: g = '{8'h15, 4'd0, 1'b0};
      14: g = '{8'h19, 4'd0, 1'b0};
      15: g = '{8'h1A, 4'd0, 1'b0};
      16: g = '{8'h1B, 4'd0, 1'b0};
      17: g = '{8'h1C, 4'd0, 1'b0};
      18: g = '{8'h21, 4'd0, 1'b1};
      19: g = '{8'h49, 4'd0, 1'b1};
      20: g = '{8'h50, 4'd0, 1'b0};
      21: g = '{8'h56, 4'd0, 1'b0};
      22: g = '{8'h57, 4'd0, 1'b0};
      23: g = '{8'h58, 4'd0, 1'b0};
      24: g = '{8'h5B, 4'd0, 1'b0};
      25: g = '{8'h5F, 4'd0, 1'b0};
      26: g = '{8'h60, 4'd5, 1'b0};
      27: g = '{8'h80, 4'd4, 1'b0};
      28: g = '{8'h90, 4'd4, 1'b0};
      29: g = '{8'hF6, 4'd0, 1'b1};
      30: g = '{8'hF7, 4'd0, 1'b1};
      31: g = '{8'hF9, 4'd0, 1'b1};
      32: g = '{8'hFB, 4'd0, 1'b1};
      33: g = '{8'hFC, 4'd0, 1'b1};
      default: g = '{8'h00, 4'd8, 1'b1};
    endcase
    return g;
  endfunction

  function automatic logic [NUM_GROUPS-1:0] priv_mask();
    logic [NUM_GROUPS-1:0] m;
    for (int unsigned i = 0; i < NUM_GROUPS; i++) m[i] = grp_desc(i).priv;
    return m;
  endfunction

endpackage

// File: rtl/opdec_group_match.sv
module opdec_group_match #(
  parameter int unsigned      OPC_W = 8,
  parameter logic [OPC_W-1:0] FIRST = '0,
  parameter int unsigned      LOG2N = 0,
  parameter bit               PRIV  = 1'b0
) (
  input  logic [OPC_W-1:0] opcode,
  input  logic             kernel,
  output logic             hit
);
  // Only the bits above the group size take part in the compare.
  localparam logic [OPC_W-1:0] CMP_MASK = {OPC_W{1'b1}} << LOG2N;
  localparam logic [OPC_W-1:0] CMP_VAL  = FIRST & CMP_MASK;

  logic prefix_eq;
  logic allowed;

  assign prefix_eq = ((opcode & CMP_MASK) == CMP_VAL);

  generate
    if (PRIV) begin : g_gated
      assign allowed = kernel;
    end else begin : g_open
      assign allowed = 1'b1;
    end
  endgenerate

  assign hit = prefix_eq & allowed;
endmodule

// File: rtl/opdec_hit_count.sv
module opdec_hit_count #(
  parameter int unsigned W = 36
) (
  input  logic [W-1:0] hits,
  output logic         conflict
);
  localparam int unsigned CW = $clog2(W + 1);

  logic [CW-1:0] cnt;

  always_comb begin
    cnt = '0;
    for (int unsigned i = 0; i < W; i++) cnt = cnt + CW'(hits[i]);
  end

  assign conflict = (cnt > CW'(1));
endmodule

// File: rtl/opgrp_decoder.sv
module opgrp_decoder
  import opdec_pkg::*;
#(
  parameter int unsigned NG = NUM_GROUPS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid_i,
  input  logic             kernel_i,
  input  logic [OPC_W-1:0] opcode_i,
  output logic [NG-1:0]    op_flags_o,
  output logic             logic_op_o,
  output logic             invalid_o,
  output logic             multi_hit_o
);
  localparam logic [NG-1:0] PRIV_GRPS = priv_mask();
  localparam int unsigned   ALL_W     = NG + 2;

  logic [NG-1:0]    grp_hit;
  logic             logic_hit;
  logic             inv_hit;
  logic [NG-1:0]    grp_q_d;
  logic             logic_d;
  logic             inv_d;
  logic             conflict;

  generate
    for (genvar g = 0; g < NG; g++) begin : g_grp
      opdec_group_match #(
        .OPC_W (OPC_W),
        .FIRST (grp_desc(g).first),
        .LOG2N (int'(grp_desc(g).log2n)),
        .PRIV  (grp_desc(g).priv)
      ) u_match (
        .opcode (opcode_i),
        .kernel (kernel_i),
        .hit    (grp_hit[g])
      );
    end
  endgenerate

  assign logic_hit = (opcode_i >= LOGIC_LO) && (opcode_i <= LOGIC_HI);
  assign inv_hit   = ~(|grp_hit) & ~logic_hit;

  // Qualify with the cycle-valid input.
  assign grp_q_d = valid_i ? grp_hit : '0;
  assign logic_d = valid_i & logic_hit;
  assign inv_d   = valid_i & inv_hit;

  opdec_hit_count #(.W(ALL_W)) u_count (
    .hits     ({grp_q_d, logic_d, inv_d}),
    .conflict (conflict)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      op_flags_o  <= '0;
      logic_op_o  <= 1'b0;
      invalid_o   <= 1'b0;
      multi_hit_o <= 1'b0;
    end else begin
      op_flags_o  <= grp_q_d;
      logic_op_o  <= logic_d;
      invalid_o   <= inv_d;
      multi_hit_o <= conflict;
    end
  end

  // R8: reset clears every output at the next edge
  p_reset_clear_r8: assert property (@(posedge clk)
    rst |=> (op_flags_o == '0 && !logic_op_o && !invalid_o && !multi_hit_o));

  // R4: idle cycle produces no output
  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> (op_flags_o == '0 && !logic_op_o && !invalid_o));

  // R5: at most one decode output per cycle
  p_onehot_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $onehot0({op_flags_o, logic_op_o, invalid_o}));

  // R3: privileged groups stay silent in user mode
  p_priv_gate_r3: assert property (@(posedge clk) disable iff (rst)
    (valid_i && !kernel_i) |=> ((op_flags_o & PRIV_GRPS) == '0));

  // R6: a valid cycle always yields exactly one decode
  p_valid_decodes_r6: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> ($countones({op_flags_o, logic_op_o, invalid_o}) == 1));

  // R9: built-in table never conflicts
  p_no_conflict_r9: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> !multi_hit_o);

  // R7: logic opcodes raise only the logic flag
  p_logic_only_r7: assert property (@(posedge clk) disable iff (rst)
    (valid_i && opcode_i >= LOGIC_LO && opcode_i <= LOGIC_HI)
      |=> (logic_op_o && op_flags_o == '0 && !invalid_o));
endmodule

// File: tb/tb_opgrp_decoder.sv
module tb_opgrp_decoder;
  localparam int NG = 34;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          valid_i = 1'b0;
  logic          kernel_i = 1'b0;
  logic [7:0]    opcode_i = 8'h00;
  logic [NG-1:0] op_flags_o;
  logic          logic_op_o;
  logic          invalid_o;
  logic          multi_hit_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  opgrp_decoder dut (
    .clk(clk), .rst(rst), .valid_i(valid_i), .kernel_i(kernel_i),
    .opcode_i(opcode_i), .op_flags_o(op_flags_o), .logic_op_o(logic_op_o),
    .invalid_o(invalid_o), .multi_hit_o(multi_hit_o)
  );

  // Behavioural reference: flag index for an opcode, -1 if none; priv set for kernel-only.
  function automatic int ref_index(input logic [7:0] op, output bit priv);
    priv = 1'b0;
    case (op) inside
      8'h01: return 0;   8'h02: return 1;   8'h03: return 2;   8'h04: return 3;
      8'h06: return 4;   8'h08: return 5;   8'h09: return 6;
      8'h0C: begin priv = 1'b1; return 7; end
      8'h0D: begin priv = 1'b1; return 8; end
      8'h0E: begin priv = 1'b1; return 9; end
      8'h10: return 10;  8'h11: return 11;  8'h14: return 12;  8'h15: return 13;
      8'h19: return 14;  8'h1A: return 15;  8'h1B: return 16;  8'h1C: return 17;
      8'h21: begin priv = 1'b1; return 18; end
      8'h49: begin priv = 1'b1; return 19; end
      8'h50: return 20;  8'h56: return 21;  8'h57: return 22;  8'h58: return 23;
      8'h5B: return 24;  8'h5F: return 25;
      [8'h60:8'h7F]: return 26;
      [8'h80:8'h8F]: return 27;
      [8'h90:8'h9F]: return 28;
      8'hF6: begin priv = 1'b1; return 29; end
      8'hF7: begin priv = 1'b1; return 30; end
      8'hF9: begin priv = 1'b1; return 31; end
      8'hFB: begin priv = 1'b1; return 32; end
      8'hFC: begin priv = 1'b1; return 33; end
      default: return -1;
    endcase
  endfunction

  task automatic check(input string req, input logic [NG+2:0] act, input logic [NG+2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s op=%02h kern=%0b valid=%0b actual=%h expected=%h",
               req, opcode_i, kernel_i, valid_i, act, exp);
    end
  endtask

  // Drive one cycle, then compare every output against the reference after the edge.
  task automatic step(input logic v, input logic k, input logic [7:0] op);
    logic [NG-1:0] ef;
    logic el, ei;
    bit   pv;
    int   idx;
    string tag;
    valid_i = v; kernel_i = k; opcode_i = op;
    idx = ref_index(op, pv);
    ef = '0; el = 1'b0; ei = 1'b0;
    if (!v)                             tag = "R4";
    else if (op >= 8'h16 && op <= 8'h18) begin el = 1'b1; tag = "R7"; end
    else if (idx >= 0 && (!pv || k)) begin
      ef[idx] = 1'b1;
      tag = (idx >= 26 && idx <= 28) ? "R2" : (pv ? "R3" : "R1");
    end else begin
      ei = 1'b1;
      tag = (idx >= 0) ? "R3" : "R6";
    end
    @(posedge clk);
    @(negedge clk);
    check(tag, {op_flags_o, logic_op_o, invalid_o, multi_hit_o}, {ef, el, ei, 1'b0});
    checks++;
    if ($countones({op_flags_o, logic_op_o, invalid_o}) > 1) begin
      errors++;
      $display("FAIL R5 op=%02h actual=%0d hot expected<=1", op,
               $countones({op_flags_o, logic_op_o, invalid_o}));
    end
    checks++;
    if (multi_hit_o !== 1'b0) begin
      errors++;
      $display("FAIL R9 op=%02h actual=%0b expected=0", op, multi_hit_o);
    end
  endtask

  initial begin
    rst = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    // R8 reset state
    check("R8", {op_flags_o, logic_op_o, invalid_o, multi_hit_o}, '0);
    rst = 1'b0;

    // Full sweep in both modes; covers R1, R2 boundaries, R3, R6, R7
    for (int k = 0; k < 2; k++)
      for (int op = 0; op < 256; op++)
        step(1'b1, k[0], op[7:0]);

    // Explicit R2 range edges
    step(1'b1, 1'b0, 8'h5F); step(1'b1, 1'b0, 8'h60);
    step(1'b1, 1'b0, 8'h7F); step(1'b1, 1'b0, 8'h80);
    step(1'b1, 1'b0, 8'h8F); step(1'b1, 1'b0, 8'h90);
    step(1'b1, 1'b0, 8'h9F); step(1'b1, 1'b0, 8'hA0);

    // R4 idle cycles interleaved with valid ones
    for (int i = 0; i < 64; i++)
      step(i[0], i[1], 8'(i * 37 + 5));

    // R8 reset while a valid opcode is held
    valid_i = 1'b1; kernel_i = 1'b1; opcode_i = 8'h0C;
    @(posedge clk); @(negedge clk);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R8", {op_flags_o, logic_op_o, invalid_o, multi_hit_o}, '0);
    rst = 1'b0;
    step(1'b1, 1'b1, 8'h0C);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule